// File: doc/BRIEF.md
# Multi-Queue Write Port Selector

This block is the write-side steering logic for a device that holds four queues behind one shared data input. Every rising edge of the write clock it samples a 5-bit write address. The address picks one of the four local queues and also carries a device number, which matters when up to eight such devices share the address lines in an expansion chain. It then turns the active-low write enable into a one-hot write strobe aimed at the selected queue. The input data is registered alongside the strobe.

A queue change does not take effect at once. The queue that was active before the change keeps receiving data on the edge that makes the selection and on the edge after it. The newly chosen queue receives data from the second edge onward.

A separate flag strobe reuses the device field of the address to decide which device in the chain owns a shared almost-full flag bus. This device raises an ownership output when it is the one picked. Queue selection is refused until configuration of the device has finished. Raising the address enable and the flag strobe together is illegal: the block reports it and acts on neither.

Top module: `mq_write_selector`

## Requirements
- R1: While reset is high, and on the first cycle after it, all queue strobes, `flag_owner`, `sel_err` and `wr_data` are 0.
- R2: Write-address bits [1:0] give the queue number n, and a write to queue n raises bit n of `q_wr_strobe`. Bits [4:2] give the device number, which is compared with parameter `DEV_ID`.
- R3: A queue selection is taken only on an edge where `addr_en` is 1, `flag_stb` is 0 and `prog_done` is 1. With `prog_done` at 0 the request is ignored and the earlier queue stays in effect.
- R4: A queue selection is taken whatever the value of `wr_en_n` on that edge.
- R5: A write happens only on an edge where `wr_en_n` is 0. Its strobe is high during the cycle after that edge. `wr_data` always shows the `din` value sampled on the previous edge.
- R6: After a selection edge, writes on that edge and on the next one still go to the previously selected queue. Writes from the second edge after it go to the new queue.
- R7: When the active selection names a device number other than `DEV_ID`, no strobe is raised.
- R8: An edge with `flag_stb` at 1 and `addr_en` at 0 sets `flag_owner` to 1 if bits [4:2] equal `DEV_ID`, and to 0 otherwise. Bits [1:0] are ignored. The value holds until the next such edge, and the edge neither changes the write queue nor stops a write to it.
- R9: An edge with `addr_en` and `flag_stb` both at 1 makes `sel_err` high for the following cycle. It leaves the queue selection and `flag_owner` unchanged.
- R10: After reset no strobe is raised until a valid selection has passed through the two-edge pipeline.
- R11: At most one bit of `q_wr_strobe` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| prog_done | input | 1 | High once device configuration has completed |
| addr_en | input | 1 | Queue-select request for the address on this edge |
| flag_stb | input | 1 | Flag-bus device-select request for this edge |
| wr_addr | input | 5 | [1:0] queue number, [4:2] device number |
| wr_en_n | input | 1 | Active-low write enable |
| din | input | DATA_W | Shared write data |
| q_wr_strobe | output | 4 | One-hot per-queue write strobe |
| wr_data | output | DATA_W | Registered write data |
| flag_owner | output | 1 | This device drives the almost-full flag bus |
| sel_err | output | 1 | Address enable and flag strobe were both high on the previous edge |

## Verification
Some rules are checked by assertions on every cycle. These are: the strobe is one-hot or zero, no strobe follows a disabled write or a foreign device number, a clash raises `sel_err` and leaves the flag owner alone, selection is refused before configuration, and flag ownership changes only on a strobe edge. Other behaviour can only be shown by the bench's scenarios, which compare against a behavioural model every clock. This covers the two-edge hand-over from the old queue to the new one, back-to-back selections, selection while writes are disabled, the silence after reset, and writes that continue across flag-strobe and clash edges.

// File: rtl/mq_wr_pkg.sv
package mq_wr_pkg;

    localparam int ADDR_W = 5;
    localparam int QSEL_W = 2;
    localparam int NUM_Q  = 1 << QSEL_W;
    localparam int DEV_W  = ADDR_W - QSEL_W;

    typedef struct packed {
        logic              vld;
        logic [DEV_W-1:0]  dev;
        logic [QSEL_W-1:0] q;
    } qsel_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_QSEL  = 2'd1,
        CMD_FSEL  = 2'd2,
        CMD_CLASH = 2'd3
    } addr_cmd_t;

    function automatic qsel_t decode_addr(input logic [ADDR_W-1:0] a);
        qsel_t s;
        s.vld = 1'b1;
        s.dev = a[ADDR_W-1:QSEL_W];
        s.q   = a[QSEL_W-1:0];
        return s;
    endfunction

    function automatic logic [NUM_Q-1:0] q_onehot(input logic [QSEL_W-1:0] q);
        logic [NUM_Q-1:0] v;
        v = '0;
        v[q] = 1'b1;
        return v;
    endfunction

    function automatic addr_cmd_t classify(input logic ae, input logic fs, input logic done);
        if (ae && fs)        return CMD_CLASH;
        else if (ae && done) return CMD_QSEL;
        else if (fs)         return CMD_FSEL;
        else                 return CMD_NONE;
    endfunction

endpackage

// File: rtl/mq_sel_pipe.sv
module mq_sel_pipe
    import mq_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  addr_cmd_t         cmd,
    input  logic [ADDR_W-1:0] addr,
    output qsel_t             act
);
    qsel_t pend;

    // Stage 1 captures the request, stage 2 makes it active one edge later.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            act  <= '0;
        end else begin
            act <= pend;
            if (cmd == CMD_QSEL)
                pend <= decode_addr(addr);
        end
    end

    // R6: an active selection always came through the pending stage
    p_act_from_pend_r6: assert property (@(posedge clk) disable iff (rst)
        (act.vld && !$past(act.vld)) |-> $past(pend.vld));

endmodule

// File: rtl/mq_wr_gate.sv
module mq_wr_gate
    import mq_wr_pkg::*;
#(
    parameter int               DATA_W = 36,
    parameter logic [DEV_W-1:0] DEV_ID = 3'd5
)(
    input  logic              clk,
    input  logic              rst,
    input  qsel_t             act,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] din,
    output logic [NUM_Q-1:0]  q_wr_strobe,
    output logic [DATA_W-1:0] wr_data
);
    logic hit;
    assign hit = act.vld && (act.dev == DEV_ID) && !wr_en_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_wr_strobe <= '0;
            wr_data     <= '0;
        end else begin
            q_wr_strobe <= hit ? q_onehot(act.q) : '0;
            wr_data     <= din;
        end
    end

    // R5: a disabled write produces no strobe
    p_idle_when_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en_n |=> (q_wr_strobe == '0));

    // R7: a foreign device number never reaches a local queue
    p_foreign_dev_r7: assert property (@(posedge clk) disable iff (rst)
        (act.vld && act.dev != DEV_ID) |=> (q_wr_strobe == '0));

    // R10: nothing is written before any selection became active
    p_no_early_write_r10: assert property (@(posedge clk) disable iff (rst)
        !act.vld |=> (q_wr_strobe == '0));

    // R11: strobe is one-hot or zero
    p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_wr_strobe));

endmodule

// File: rtl/mq_flag_owner.sv
module mq_flag_owner
    import mq_wr_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ID = 3'd5
)(
    input  logic              clk,
    input  logic              rst,
    input  addr_cmd_t         cmd,
    input  logic [ADDR_W-1:0] addr,
    output logic              flag_owner,
    output logic              sel_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_owner <= 1'b0;
            sel_err    <= 1'b0;
        end else begin
            sel_err <= (cmd == CMD_CLASH);
            if (cmd == CMD_FSEL)
                flag_owner <= (addr[ADDR_W-1:QSEL_W] == DEV_ID);
        end
    end

    // R8: ownership only moves on a flag-strobe edge
    p_owner_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_FSEL) |=> $stable(flag_owner));

endmodule

// File: rtl/mq_write_selector.sv
module mq_write_selector
    import mq_wr_pkg::*;
#(
    parameter int               DATA_W = 36,
    parameter logic [DEV_W-1:0] DEV_ID = 3'd5
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_done,
    input  logic              addr_en,
    input  logic              flag_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] din,
    output logic [NUM_Q-1:0]  q_wr_strobe,
    output logic [DATA_W-1:0] wr_data,
    output logic              flag_owner,
    output logic              sel_err
);
    addr_cmd_t cmd;
    qsel_t     act;

    assign cmd = classify(addr_en, flag_stb, prog_done);

    mq_sel_pipe u_pipe (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .addr (wr_addr),
        .act  (act)
    );

    mq_wr_gate #(.DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .wr_en_n     (wr_en_n),
        .din         (din),
        .q_wr_strobe (q_wr_strobe),
        .wr_data     (wr_data)
    );

    mq_flag_owner #(.DEV_ID(DEV_ID)) u_flag (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .addr       (wr_addr),
        .flag_owner (flag_owner),
        .sel_err    (sel_err)
    );

    // R3: no queue selection is decoded before configuration completes
    p_cfg_block_r3: assert property (@(posedge clk) disable iff (rst)
        !prog_done |-> (cmd != CMD_QSEL));

    // R9: a clash is reported and leaves flag ownership untouched
    p_clash_r9: assert property (@(posedge clk) disable iff (rst)
        (addr_en && flag_stb) |=> (sel_err && $stable(flag_owner)));

    // R5: a strobe always traces back to an enabled write
    p_strobe_needs_wen_r5: assert property (@(posedge clk) disable iff (rst)
        (q_wr_strobe != '0) |-> !$past(wr_en_n));

endmodule

// File: tb/mq_write_selector_tb.sv
module mq_write_selector_tb;
    localparam int         DW = 36;
    localparam logic [2:0] ID = 3'd5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_done = 1'b0;
    logic          addr_en = 1'b0;
    logic          flag_stb = 1'b0;
    logic [4:0]    wr_addr = '0;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [3:0]    q_wr_strobe;
    logic [DW-1:0] wr_data;
    logic          flag_owner;
    logic          sel_err;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done_flag = 0;
    string tag = "R1";

    always #4 clk = ~clk; // 125 MHz

    mq_write_selector #(.DATA_W(DW), .DEV_ID(ID)) u_dut (
        .clk(clk), .rst(rst), .prog_done(prog_done), .addr_en(addr_en),
        .flag_stb(flag_stb), .wr_addr(wr_addr), .wr_en_n(wr_en_n), .din(din),
        .q_wr_strobe(q_wr_strobe), .wr_data(wr_data),
        .flag_owner(flag_owner), .sel_err(sel_err)
    );

    // Behavioural reference model
    logic          m_pv, m_av;
    logic [2:0]    m_pd, m_ad;
    logic [1:0]    m_pq, m_aq;
    logic [3:0]    m_stb;
    logic [DW-1:0] m_data;
    logic          m_own, m_err;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_pv = 0; m_av = 0; m_pd = 0; m_ad = 0; m_pq = 0; m_aq = 0;
            m_stb = 0; m_data = 0; m_own = 0; m_err = 0;
        end else begin
            m_stb  = (!wr_en_n && m_av && m_ad == ID) ? (4'b0001 << m_aq) : 4'b0000;
            m_data = din;
            m_av = m_pv; m_ad = m_pd; m_aq = m_pq;
            m_err = addr_en && flag_stb;
            if (addr_en && !flag_stb && prog_done) begin
                m_pv = 1; m_pd = wr_addr[4:2]; m_pq = wr_addr[1:0];
            end
            if (flag_stb && !addr_en) m_own = (wr_addr[4:2] == ID);
        end
    end

    task automatic check_now();
        n_vec++;
        if (q_wr_strobe !== m_stb || wr_data !== m_data ||
            flag_owner !== m_own || sel_err !== m_err) begin
            n_bad++;
            $display("FAIL %s: strobe=%b data=%h own=%b err=%b expected strobe=%b data=%h own=%b err=%b",
                     tag, q_wr_strobe, wr_data, flag_owner, sel_err,
                     m_stb, m_data, m_own, m_err);
        end
    endtask

    // One cycle: check outputs of the last edge, then drive the next inputs
    task automatic step(input logic ae, input logic fs, input logic [4:0] a,
                        input logic wn, input string t);
        @(negedge clk);
        check_now();
        tag      = t;
        addr_en  = ae;
        flag_stb = fs;
        wr_addr  = a;
        wr_en_n  = wn;
        din      = {n_vec[3:0], n_vec[31:0] * 32'h9E3779B1};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_now();                       // R1: during reset
        rst = 1'b0;
        prog_done = 1'b0;
        // R1 and R10: writes requested but nothing selected yet
        for (int i = 0; i < 4; i++) step(0, 0, 5'd0, 0, "R10");
        // R3: selection before configuration is ignored
        for (int i = 0; i < 3; i++) step(1, 0, {ID, 2'd1}, 0, "R3");
        for (int i = 0; i < 3; i++) step(0, 0, 5'd0, 0, "R3");
        prog_done = 1'b1;
        // R2, R6: select queue 1 with writes running, then move to queue 3
        step(1, 0, {ID, 2'd1}, 0, "R6");
        for (int i = 0; i < 4; i++) step(0, 0, 5'd0, 0, "R6");
        step(1, 0, {ID, 2'd3}, 0, "R6");
        for (int i = 0; i < 4; i++) step(0, 0, 5'd0, 0, "R2");
        // R6: back-to-back selections 0 then 2
        step(1, 0, {ID, 2'd0}, 0, "R6");
        step(1, 0, {ID, 2'd2}, 0, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 5'd0, 0, "R6");
        // R4: select queue 1 while writes are off, then write
        step(1, 0, {ID, 2'd1}, 1, "R4");
        for (int i = 0; i < 2; i++) step(0, 0, 5'd0, 1, "R4");
        for (int i = 0; i < 3; i++) step(0, 0, 5'd0, 0, "R4");
        // R5: interleaved write enable
        for (int i = 0; i < 6; i++) step(0, 0, 5'd0, logic'(i[0]), "R5");
        // R7: foreign device gets no strobes
        step(1, 0, {3'd2, 2'd0}, 0, "R7");
        for (int i = 0; i < 4; i++) step(0, 0, 5'd0, 0, "R7");
        step(1, 0, {ID, 2'd2}, 0, "R7");
        for (int i = 0; i < 3; i++) step(0, 0, 5'd0, 0, "R7");
        // R8: flag strobe picks this device, then another; writes continue
        step(0, 1, {ID, 2'd3}, 0, "R8");
        for (int i = 0; i < 3; i++) step(0, 0, 5'd0, 0, "R8");
        step(0, 1, {3'd1, 2'd0}, 0, "R8");
        for (int i = 0; i < 2; i++) step(0, 0, 5'd0, 0, "R8");
        step(0, 1, {ID, 2'd1}, 0, "R8");
        step(0, 0, 5'd0, 0, "R8");
        // R9: clash leaves queue and owner alone
        step(1, 1, {3'd0, 2'd0}, 0, "R9");
        for (int i = 0; i < 4; i++) step(0, 0, 5'd0, 0, "R9");
        // R11: many selections with continuous writes
        for (int i = 0; i < 16; i++) step(logic'(i % 3 == 0), 0, {ID, i[1:0]}, 0, "R11");
        step(0, 0, 5'd0, 1, "R11");
        @(negedge clk);
        check_now();
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 5000);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule